// File: doc/BRIEF.md
# Program Counter Update Unit for a Multi-Cycle Processor

This block keeps the program counter of a 32-bit processor that runs each instruction over several clock steps. It also keeps a second register that holds a branch destination. The datapath has a single shared ALU. That ALU works out the branch destination during the decode step. In a later step the same ALU compares the two branch operands. The destination therefore has to be saved in a register of its own in between.

Each clock edge, the unit picks one of three candidates for the next PC:
- the ALU result,
- the saved branch destination,
- a jump address built from the top bits of the current PC and the instruction's index field.

The PC loads on an unconditional strobe. It also loads on a conditional strobe, but only when the ALU reports zero. The control sequencer, the ALU and the instruction register sit outside the block and drive its inputs directly. Both outputs come straight from flops.

Top module: `pcu_pc_update`

## Requirements
- R1: A synchronous active-high reset clears both the PC and the branch-destination register to 0. After reset is released, both outputs read 0 until a write strobe loads them.
- R2: With pc_sel = 2'b00 and pc_ld asserted, the PC takes the ALU result at the next rising edge. Repeated loads of PC+4 give a sequential run of addresses.
- R3: With pc_sel = 2'b01 and a load enabled, the PC takes the value held in the branch-destination register.
- R4: With pc_sel = 2'b10 and a load enabled, the PC becomes {current PC[31:28], jmp_index[25:0], 2'b00}.
- R5: The branch-destination register loads the ALU result at an edge where tgt_ld is high. At every other edge it keeps its value.
- R6: With pc_ld low and pc_ld_if_zero high, the PC loads when alu_zero is 1 (branch taken). It holds when alu_zero is 0 (branch not taken).
- R7: With pc_ld and pc_ld_if_zero both low, the PC holds its value whatever alu_zero is.
- R8: pc_sel = 2'b11 is reserved. Under it the PC holds, even when pc_ld is asserted or a conditional load would fire.
- R9: pc_ld loads the PC whether alu_zero is 0 or 1.
- R10: When tgt_ld and a load from the destination register (pc_sel = 2'b01) occur at the same edge, the PC receives the value the register held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| alu_result | input | 32 | Output of the shared ALU |
| alu_zero | input | 1 | ALU zero flag from the branch compare |
| jmp_index | input | 26 | Low 26 bits of the instruction register |
| pc_ld | input | 1 | Unconditional PC load strobe |
| pc_ld_if_zero | input | 1 | PC load strobe gated by alu_zero |
| tgt_ld | input | 1 | Load strobe for the branch-destination register |
| pc_sel | input | 2 | Next-PC source: 00 ALU, 01 destination register, 10 jump, 11 reserved |
| pc_q | output | 32 | Current program counter |
| tgt_q | output | 32 | Stored branch destination |

## Verification
The bench runs a short program-shaped sequence of steps: fetch increments, decode steps that save a destination, taken and not-taken compares, and jumps. It compares the PC with a model it computes on its own.

Each error has a visible symptom:
- A strobe gate that ignored alu_zero would let a not-taken branch redirect the PC.
- An unconditional load that was still gated by alu_zero would freeze the PC.
- A jump that took its top nibble from the ALU instead of the current PC would land in the wrong 256 MB region.
- A reserved select that fell through to a real source would corrupt the PC.
- A destination register that loaded without its strobe, or that bypassed the new value straight to the PC mux, would send the branch to the wrong place.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  typedef enum logic [1:0] {
    SRC_ALU  = 2'b00,
    SRC_TGT  = 2'b01,
    SRC_JUMP = 2'b10,
    SRC_RSVD = 2'b11
  } pc_src_e;
endpackage

// File: rtl/pcu_target_reg.sv
module pcu_target_reg #(
  parameter int XLEN = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ld,
  input  logic [XLEN-1:0] d,
  output logic [XLEN-1:0] q
);
  // Holds the branch destination across the cycle in which the ALU is reused
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (ld) q <= d;
  end
endmodule

// File: rtl/pcu_jump_addr.sv
module pcu_jump_addr #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26,
  localparam int RGN_W = XLEN - IDX_W - 2
) (
  input  logic [RGN_W-1:0] pc_region,
  input  logic [IDX_W-1:0] index,
  output logic [XLEN-1:0]  addr
);
  // Word-aligned target inside the region of the current PC
  always_comb addr = {pc_region, index, 2'b00};
endmodule

// File: rtl/pcu_next_sel.sv
module pcu_next_sel #(
  parameter int XLEN = 32
) (
  input  pcu_pkg::pc_src_e sel,
  input  logic [XLEN-1:0]  from_alu,
  input  logic [XLEN-1:0]  from_tgt,
  input  logic [XLEN-1:0]  from_jump,
  input  logic             ld,
  input  logic             ld_if_zero,
  input  logic             zero,
  output logic [XLEN-1:0]  next_pc,
  output logic             en
);
  import pcu_pkg::*;
  logic sel_valid;

  always_comb begin
    sel_valid = 1'b1;
    unique case (sel)
      SRC_ALU:  next_pc = from_alu;
      SRC_TGT:  next_pc = from_tgt;
      SRC_JUMP: next_pc = from_jump;
      default: begin
        next_pc   = from_alu;
        sel_valid = 1'b0;
      end
    endcase
    en = sel_valid & (ld | (ld_if_zero & zero));
  end
endmodule

// File: rtl/pcu_pc_update.sv
module pcu_pc_update #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [XLEN-1:0]  alu_result,
  input  logic             alu_zero,
  input  logic [IDX_W-1:0] jmp_index,
  input  logic             pc_ld,
  input  logic             pc_ld_if_zero,
  input  logic             tgt_ld,
  input  logic [1:0]       pc_sel,
  output logic [XLEN-1:0]  pc_q,
  output logic [XLEN-1:0]  tgt_q
);
  import pcu_pkg::*;
  localparam int RGN_W = XLEN - IDX_W - 2;

  logic [XLEN-1:0] jump_addr;
  logic [XLEN-1:0] next_pc;
  logic            pc_en;

  pcu_target_reg #(.XLEN(XLEN)) u_tgt (
    .clk (clk),
    .rst (rst),
    .ld  (tgt_ld),
    .d   (alu_result),
    .q   (tgt_q)
  );

  pcu_jump_addr #(.XLEN(XLEN), .IDX_W(IDX_W)) u_jump (
    .pc_region (pc_q[XLEN-1 -: RGN_W]),
    .index     (jmp_index),
    .addr      (jump_addr)
  );

  pcu_next_sel #(.XLEN(XLEN)) u_sel (
    .sel        (pc_src_e'(pc_sel)),
    .from_alu   (alu_result),
    .from_tgt   (tgt_q),
    .from_jump  (jump_addr),
    .ld         (pc_ld),
    .ld_if_zero (pc_ld_if_zero),
    .zero       (alu_zero),
    .next_pc    (next_pc),
    .en         (pc_en)
  );

  always_ff @(posedge clk) begin
    if (rst)        pc_q <= '0;
    else if (pc_en) pc_q <= next_pc;
  end
endmodule

// File: rtl/pcu_pc_update_chk.sv
module pcu_pc_update_chk #(
  parameter int XLEN  = 32,
  parameter int IDX_W = 26
) (
  input logic             clk,
  input logic             rst,
  input logic [XLEN-1:0]  alu_result,
  input logic             alu_zero,
  input logic [IDX_W-1:0] jmp_index,
  input logic             pc_ld,
  input logic             pc_ld_if_zero,
  input logic             tgt_ld,
  input logic [1:0]       pc_sel,
  input logic [XLEN-1:0]  pc_q,
  input logic [XLEN-1:0]  tgt_q
);
  localparam int RGN_W = XLEN - IDX_W - 2;
  logic live;

  always_ff @(posedge clk) begin
    if (rst) live <= 1'b0;
    else     live <= 1'b1;
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_q == '0 && tgt_q == '0));

  // R5
  tgt_load_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(tgt_ld)) |-> tgt_q == $past(alu_result));

  // R5
  tgt_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(!tgt_ld)) |-> $stable(tgt_q));

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(!pc_ld && !pc_ld_if_zero)) |-> $stable(pc_q));

  // R6
  not_taken_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(!pc_ld && pc_ld_if_zero && !alu_zero)) |-> $stable(pc_q));

  // R8
  rsvd_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(pc_sel == 2'b11)) |-> $stable(pc_q));

  // R4
  jump_form_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(pc_ld && pc_sel == 2'b10)) |->
      pc_q == {$past(pc_q[XLEN-1 -: RGN_W]), $past(jmp_index), 2'b00});

  // R10
  tgt_old_value_chk: assert property (@(posedge clk) disable iff (rst)
    (live && $past(pc_ld && pc_sel == 2'b01)) |-> pc_q == $past(tgt_q));
endmodule

bind pcu_pc_update pcu_pc_update_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .alu_result    (alu_result),
  .alu_zero      (alu_zero),
  .jmp_index     (jmp_index),
  .pc_ld         (pc_ld),
  .pc_ld_if_zero (pc_ld_if_zero),
  .tgt_ld        (tgt_ld),
  .pc_sel        (pc_sel),
  .pc_q          (pc_q),
  .tgt_q         (tgt_q)
);

// File: tb/tb_pcu_pc_update.sv
module tb_pcu_pc_update;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] alu_result = '0;
  logic        alu_zero = 1'b0;
  logic [25:0] jmp_index = '0;
  logic        pc_ld = 1'b0;
  logic        pc_ld_if_zero = 1'b0;
  logic        tgt_ld = 1'b0;
  logic [1:0]  pc_sel = 2'b00;
  logic [31:0] pc_q, tgt_q;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_pc = '0;
  logic [31:0] exp_tgt = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pcu_pc_update dut (
    .clk(clk), .rst(rst), .alu_result(alu_result), .alu_zero(alu_zero),
    .jmp_index(jmp_index), .pc_ld(pc_ld), .pc_ld_if_zero(pc_ld_if_zero),
    .tgt_ld(tgt_ld), .pc_sel(pc_sel), .pc_q(pc_q), .tgt_q(tgt_q)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Drive one control step at the falling edge, let the rising edge act, sample 1 time unit later
  task automatic step(input logic ld, input logic ldz, input logic z, input logic tld,
                      input logic [1:0] sel, input logic [31:0] alu, input logic [25:0] idx);
    @(negedge clk);
    pc_ld = ld; pc_ld_if_zero = ldz; alu_zero = z; tgt_ld = tld;
    pc_sel = sel; alu_result = alu; jmp_index = idx;
    @(posedge clk);
    #1;
    @(negedge clk);
    pc_ld = 1'b0; pc_ld_if_zero = 1'b0; tgt_ld = 1'b0;
  endtask

  function automatic logic [31:0] br_dest(input logic [31:0] pc4, input logic [15:0] off);
    return pc4 + {{14{off[15]}}, off, 2'b00};
  endfunction

  task automatic t_reset();
    @(negedge clk); rst = 1'b1;
    alu_result = 32'hFFFF_FFFF; pc_ld = 1'b1; tgt_ld = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); rst = 1'b0; pc_ld = 1'b0; tgt_ld = 1'b0;
    exp_pc = '0; exp_tgt = '0;
    check("R1 pc after reset", pc_q, 32'h0);
    check("R1 target after reset", tgt_q, 32'h0);
  endtask

  task automatic t_fetch_seq();
    for (int i = 0; i < 4; i++) begin
      exp_pc = exp_pc + 32'd4;
      step(1'b1, 1'b0, i[0], 1'b0, 2'b00, exp_pc, '0);
      check("R2 sequential fetch", pc_q, exp_pc);
    end
    // R9: unconditional load ignores a zero flag of 0 and of 1
    exp_pc = 32'h0000_0100;
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, exp_pc, '0);
    check("R9 load with zero=0", pc_q, exp_pc);
    exp_pc = 32'h0000_0200;
    step(1'b1, 1'b0, 1'b1, 1'b0, 2'b00, exp_pc, '0);
    check("R9 load with zero=1", pc_q, exp_pc);
  endtask

  task automatic t_branch(input logic taken, input logic [15:0] off);
    logic [31:0] dest;
    exp_pc = exp_pc + 32'd4;
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, exp_pc, '0);
    dest = br_dest(exp_pc, off);
    step(1'b0, 1'b0, 1'b0, 1'b1, 2'b00, dest, '0);
    exp_tgt = dest;
    check("R5 target loaded", tgt_q, exp_tgt);
    check("R7 pc held in decode", pc_q, exp_pc);
    step(1'b0, 1'b1, taken, 1'b0, 2'b01, 32'h1234_5678, '0);
    if (taken) begin
      exp_pc = dest;
      check("R3 R6 taken branch", pc_q, exp_pc);
    end else begin
      check("R6 not-taken branch holds", pc_q, exp_pc);
    end
    check("R5 target held", tgt_q, exp_tgt);
  endtask

  task automatic t_jump();
    exp_pc = 32'hA000_0010;
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'b00, exp_pc, '0);
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'b10, 32'h5555_5555, 26'h0123456);
    exp_pc = {4'hA, 26'h0123456, 2'b00};
    check("R4 jump address", pc_q, exp_pc);
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b10, 32'h0, 26'h3FFFFFF);
    exp_pc = {4'hA, 26'h3FFFFFF, 2'b00};
    check("R4 conditional jump source", pc_q, exp_pc);
  endtask

  task automatic t_idle_reserved();
    step(1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'hDEAD_BEEF, '0);
    check("R7 idle with zero=1", pc_q, exp_pc);
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'b11, 32'hDEAD_BEEF, 26'h155);
    check("R8 reserved select with pc_ld", pc_q, exp_pc);
    step(1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 32'hCAFE_0000, 26'h2AA);
    check("R8 reserved select with conditional load", pc_q, exp_pc);
    check("R5 target untouched", tgt_q, exp_tgt);
  endtask

  task automatic t_same_cycle();
    logic [31:0] old_tgt;
    old_tgt = exp_tgt;
    step(1'b1, 1'b0, 1'b0, 1'b1, 2'b01, 32'h0BAD_F00C, '0);
    exp_pc = old_tgt; exp_tgt = 32'h0BAD_F00C;
    check("R10 pc takes old target", pc_q, exp_pc);
    check("R10 target takes new value", tgt_q, exp_tgt);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(posedge clk);
    t_reset();
    t_fetch_seq();
    t_branch(1'b1, 16'h0010);
    t_branch(1'b0, 16'h0020);
    t_branch(1'b1, 16'hFFF0);
    t_jump();
    t_idle_reserved();
    t_same_cycle();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule